// File: doc/BRIEF.md
# Integer ALU and Branch Unit

This block carries out the integer side of a small vector coprocessor. It holds sixteen 16-bit integer registers and, for each issued operation, reads two of them, computes a register-register or register-immediate result and reports the register writeback one cycle later. Register 0 is hard-wired to zero.

It also decides control transfers. Conditional branches, unconditional branches and register jumps compute a target. The target is held while exactly one further instruction, the delay slot, is issued. After that instruction issues, a one-cycle `jmp_valid` pulse presents the target. Link variants also write the return point to a register. Addresses are byte addresses of 8-byte instruction pairs. Link values and register jump targets count in pair units.

The jump controller is a three-state machine. `JS_IDLE` means nothing is pending. `JS_SLOT` means a transfer is armed and waits for the delay-slot issue. `JS_FIRE` is the one cycle in which the result is presented. Its transitions are:
- arm: `JS_IDLE` or `JS_FIRE` to `JS_SLOT`, when a control operation issues.
- slot: `JS_SLOT` to `JS_FIRE`, when any operation issues.
- hold: `JS_SLOT` to `JS_SLOT`, while nothing issues.
- retire: `JS_FIRE` to `JS_IDLE`, otherwise.
- rest: `JS_IDLE` to `JS_IDLE`, otherwise.

Top module: `ialu_top`

## Requirements
- R1: Register 0 always reads as zero. A result aimed at register 0 is discarded and raises no `wb_en`.
- R2: `ADD_RR`, `SUB_RR`, `AND_RR` and `OR_RR` write s+t, s−t, s&t and s|t, modulo 2^16, to register d.
- R3: `ADD_I5` writes s plus `imm5`, sign-extended from its bit 4, to register t.
- R4: `ADD_I15` and `SUB_I15` write s plus, or s minus, the zero-extended 15-bit value {`imm_hi`,`imm_lo`} to register t. `imm_hi` forms bits 14..11 of that value.
- R5: `BR_EQ` is taken when registers s and t are equal. `BR_NE` is taken when they differ.
- R6: `BR_LTZ` is taken when bit 15 of s is 1, and `BR_GEZ` when it is 0. `BR_GTZ` is taken when s, read as signed 16-bit, is greater than zero, and `BR_LEZ` when it is less than or equal to zero.
- R7: The target of a pc-relative branch (`BR`, `BR_LINK` and the conditional branches) is (pc + 8 + sign-extended `imm_lo` × 8) mod 2^14.
- R8: `BR_LINK` and `JMP_REG_LINK` write (pc + 16) / 8 to register t.
- R9: `JMP_REG` and `JMP_REG_LINK` target register s shifted left by 3, giving a 19-bit target.
- R10: The transfer resolves on the clock edge at which the next operation issues. In the cycle after that edge, `jmp_valid` is 1 for exactly one cycle if the transfer was taken. If it was not taken, `jmp_valid` stays 0 and `jmp_target` is all ones. While no operation issues, the armed transfer waits.
- R11: A control operation issued in the delay slot still writes its link register, but its own transfer is discarded.
- R12: After reset all registers are zero, `wb_en` and `jmp_valid` are 0, and `jmp_target` is all ones.
- R13: Op codes outside the defined set change no register, raise no writeback and arm no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation issues this cycle |
| op_code | input | 5 | Operation, encoded by the `op_e` type of `ialu_pkg` |
| idx_s | input | 4 | First source register |
| idx_t | input | 4 | Second source register, or destination of immediate and link forms |
| idx_d | input | 4 | Destination of register-register forms |
| imm_lo | input | 11 | Low immediate field, also the branch offset |
| imm_hi | input | 4 | High part of the 15-bit immediate |
| imm5 | input | 5 | Signed 5-bit immediate |
| pc | input | 14 | Byte address of the issuing instruction pair |
| wb_en | output | 1 | A register was written at the last edge |
| wb_idx | output | 4 | Register written |
| wb_data | output | 16 | Value written |
| jmp_valid | output | 1 | One-cycle pulse that presents a taken transfer |
| jmp_target | output | 19 | Pending or fired target, all ones when not taken |

## Verification
A corrupted register shows at the ports only when a later operation reads it. The random stream therefore mixes many reads of freshly written registers, so a bad value surfaces in `wb_data` or in a branch decision within a few issues. A wrong jump state appears as a missing, early, late or repeated `jmp_valid` pulse. Directed sequences cover a slot that waits through idle cycles, a branch placed in a delay slot, and a not-taken transfer. Each of these shows the fault in the cycle after the delay slot issues.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
    localparam int OP_W  = 5;
    localparam int LO_W  = 11;
    localparam int HI_W  = 4;
    localparam int I5_W  = 5;
    localparam int PAIR_SH = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP          = 5'd0,
        OP_ADD_RR       = 5'd1,
        OP_SUB_RR       = 5'd2,
        OP_AND_RR       = 5'd3,
        OP_OR_RR        = 5'd4,
        OP_ADD_I5       = 5'd5,
        OP_ADD_I15      = 5'd6,
        OP_SUB_I15      = 5'd7,
        OP_BR           = 5'd8,
        OP_BR_LINK      = 5'd9,
        OP_JMP_REG      = 5'd10,
        OP_JMP_REG_LINK = 5'd11,
        OP_BR_EQ        = 5'd12,
        OP_BR_NE        = 5'd13,
        OP_BR_LTZ       = 5'd14,
        OP_BR_GTZ       = 5'd15,
        OP_BR_LEZ       = 5'd16,
        OP_BR_GEZ       = 5'd17
    } op_e;

    typedef enum logic [1:0] {
        JS_IDLE = 2'd0,
        JS_SLOT = 2'd1,
        JS_FIRE = 2'd2
    } jstate_e;
endpackage

// File: rtl/ialu_regfile.sv
module ialu_regfile #(
    parameter int XLEN = 16,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [XLEN-1:0] wdata,
    input  logic [IW-1:0]   ridx_a,
    input  logic [IW-1:0]   ridx_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);
    logic [XLEN-1:0] regs [NREG];

    // Entry 0 is reset and never written, so it stays zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            for (int i = 1; i < NREG; i++) begin
                if (widx == IW'(i)) regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata_a = (ridx_a == '0) ? '0 : regs[ridx_a];
        rdata_b = (ridx_b == '0) ? '0 : regs[ridx_b];
    end
endmodule

// File: rtl/ialu_exec.sv
module ialu_exec import ialu_pkg::*; #(
    parameter int XLEN = 16,
    parameter int PC_W = 14,
    parameter int IW   = 4,
    localparam int TW  = XLEN + PAIR_SH
) (
    input  op_e              op,
    input  logic [IW-1:0]    idx_t,
    input  logic [IW-1:0]    idx_d,
    input  logic [XLEN-1:0]  va,
    input  logic [XLEN-1:0]  vb,
    input  logic [LO_W-1:0]  imm_lo,
    input  logic [HI_W-1:0]  imm_hi,
    input  logic [I5_W-1:0]  imm5,
    input  logic [PC_W-1:0]  pc,
    output logic             wr_en,
    output logic [IW-1:0]    wr_idx,
    output logic [XLEN-1:0]  wr_data,
    output logic             is_ctl,
    output logic             taken,
    output logic [TW-1:0]    target
);
    logic [XLEN-1:0] imm15_z, imm5_s, link_val;
    logic [PC_W-1:0] rel_tgt;
    logic [PC_W:0]   pc_next2;
    logic            s_neg, s_zero;

    assign imm15_z  = XLEN'({imm_hi, imm_lo});
    assign imm5_s   = {{(XLEN-I5_W){imm5[I5_W-1]}}, imm5};
    assign pc_next2 = {1'b0, pc} + (PC_W+1)'(16);
    assign link_val = XLEN'(pc_next2 >> PAIR_SH);
    assign rel_tgt  = pc + PC_W'(8)
                    + PC_W'({{(PC_W){imm_lo[LO_W-1]}}, imm_lo, {PAIR_SH{1'b0}}});
    assign s_neg    = va[XLEN-1];
    assign s_zero   = (va == '0);

    logic wr_any;
    always_comb begin
        wr_any  = 1'b0;
        wr_idx  = idx_t;
        wr_data = '0;
        is_ctl  = 1'b0;
        taken   = 1'b0;
        target  = TW'(rel_tgt);
        unique case (op)
            OP_ADD_RR:  begin wr_any = 1'b1; wr_idx = idx_d; wr_data = va + vb; end
            OP_SUB_RR:  begin wr_any = 1'b1; wr_idx = idx_d; wr_data = va - vb; end
            OP_AND_RR:  begin wr_any = 1'b1; wr_idx = idx_d; wr_data = va & vb; end
            OP_OR_RR:   begin wr_any = 1'b1; wr_idx = idx_d; wr_data = va | vb; end
            OP_ADD_I5:  begin wr_any = 1'b1; wr_data = va + imm5_s; end
            OP_ADD_I15: begin wr_any = 1'b1; wr_data = va + imm15_z; end
            OP_SUB_I15: begin wr_any = 1'b1; wr_data = va - imm15_z; end
            OP_BR:      begin is_ctl = 1'b1; taken = 1'b1; end
            OP_BR_LINK: begin
                is_ctl = 1'b1; taken = 1'b1;
                wr_any = 1'b1; wr_data = link_val;
            end
            OP_JMP_REG: begin
                is_ctl = 1'b1; taken = 1'b1; target = {va, {PAIR_SH{1'b0}}};
            end
            OP_JMP_REG_LINK: begin
                is_ctl = 1'b1; taken = 1'b1; target = {va, {PAIR_SH{1'b0}}};
                wr_any = 1'b1; wr_data = link_val;
            end
            OP_BR_EQ:   begin is_ctl = 1'b1; taken = (va == vb); end
            OP_BR_NE:   begin is_ctl = 1'b1; taken = (va != vb); end
            OP_BR_LTZ:  begin is_ctl = 1'b1; taken = s_neg; end
            OP_BR_GEZ:  begin is_ctl = 1'b1; taken = !s_neg; end
            OP_BR_GTZ:  begin is_ctl = 1'b1; taken = !s_neg && !s_zero; end
            OP_BR_LEZ:  begin is_ctl = 1'b1; taken = s_neg || s_zero; end
            default:    begin end
        endcase
        wr_en = wr_any && (wr_idx != '0);
    end
endmodule

// File: rtl/ialu_jump_seq.sv
module ialu_jump_seq import ialu_pkg::*; #(
    parameter int TW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          is_ctl,
    input  logic          taken,
    input  logic [TW-1:0] target,
    output logic          jmp_valid,
    output logic [TW-1:0] jmp_target
);
    localparam logic [TW-1:0] NO_TGT = '1;

    jstate_e       state, state_nx;
    logic          taken_q;
    logic [TW-1:0] tgt_q;
    logic          arm;

    always_comb begin
        state_nx = state;
        arm      = 1'b0;
        unique case (state)
            JS_IDLE: if (issue && is_ctl) begin state_nx = JS_SLOT; arm = 1'b1; end
            JS_SLOT: if (issue) state_nx = JS_FIRE;
            JS_FIRE: begin
                if (issue && is_ctl) begin state_nx = JS_SLOT; arm = 1'b1; end
                else                   state_nx = JS_IDLE;
            end
            default: state_nx = JS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= JS_IDLE;
            taken_q <= 1'b0;
            tgt_q   <= NO_TGT;
        end else begin
            state <= state_nx;
            if (arm) begin
                taken_q <= taken;
                tgt_q   <= taken ? target : NO_TGT;
            end
        end
    end

    always_comb begin
        jmp_valid  = (state == JS_FIRE) && taken_q;
        jmp_target = tgt_q;
    end

    assert_fire_from_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == JS_FIRE) |-> ($past(state) == JS_SLOT && $past(issue)));
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_valid |=> !jmp_valid);
    assert_pulse_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_valid |-> (jmp_target != NO_TGT));
    assert_slot_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == JS_SLOT && !issue) |=> (state == JS_SLOT && $stable(jmp_target)));
endmodule

// File: rtl/ialu_top.sv
module ialu_top import ialu_pkg::*; #(
    parameter int XLEN = 16,
    parameter int NREG = 16,
    parameter int PC_W = 14,
    localparam int IW  = $clog2(NREG),
    localparam int TW  = XLEN + PAIR_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic [IW-1:0]    idx_s,
    input  logic [IW-1:0]    idx_t,
    input  logic [IW-1:0]    idx_d,
    input  logic [LO_W-1:0]  imm_lo,
    input  logic [HI_W-1:0]  imm_hi,
    input  logic [I5_W-1:0]  imm5,
    input  logic [PC_W-1:0]  pc,
    output logic             wb_en,
    output logic [IW-1:0]    wb_idx,
    output logic [XLEN-1:0]  wb_data,
    output logic             jmp_valid,
    output logic [TW-1:0]    jmp_target
);
    logic [XLEN-1:0] va, vb, wr_data;
    logic [IW-1:0]   wr_idx;
    logic            wr_en, is_ctl, taken, we;
    logic [TW-1:0]   target;

    assign we = issue_valid && wr_en;

    ialu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .widx(wr_idx), .wdata(wr_data),
        .ridx_a(idx_s), .ridx_b(idx_t), .rdata_a(va), .rdata_b(vb)
    );

    ialu_exec #(.XLEN(XLEN), .PC_W(PC_W), .IW(IW)) u_exec (
        .op(op_e'(op_code)), .idx_t(idx_t), .idx_d(idx_d), .va(va), .vb(vb),
        .imm_lo(imm_lo), .imm_hi(imm_hi), .imm5(imm5), .pc(pc),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .is_ctl(is_ctl), .taken(taken), .target(target)
    );

    ialu_jump_seq #(.TW(TW)) u_seq (
        .clk(clk), .rst_n(rst_n), .issue(issue_valid), .is_ctl(is_ctl),
        .taken(taken), .target(target),
        .jmp_valid(jmp_valid), .jmp_target(jmp_target)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_en   <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            wb_en <= we;
            if (we) begin
                wb_idx  <= wr_idx;
                wb_data <= wr_data;
            end
        end
    end

    assert_no_r0_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != '0));
    assert_link_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op_code == OP_BR_LINK && idx_t != '0) |=>
        (wb_en && wb_data == XLEN'((((PC_W+1)'($past(pc))) + (PC_W+1)'(16)) >> PAIR_SH)));
endmodule

// File: tb/ialu_top_bench.sv
module ialu_top_bench;
    import ialu_pkg::*;

    localparam time CLK_P = 20ns;
    localparam logic [18:0] NO_TGT = '1;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [3:0]  idx_s = '0, idx_t = '0, idx_d = '0, imm_hi = '0;
    logic [10:0] imm_lo = '0;
    logic [4:0]  imm5 = '0;
    logic [13:0] pc = '0;
    logic        wb_en, jmp_valid;
    logic [3:0]  wb_idx;
    logic [15:0] wb_data;
    logic [18:0] jmp_target;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [15:0] m [16];
    int          js = 0;
    logic        p_taken = 0;
    logic [18:0] p_tgt = NO_TGT;

    always #(CLK_P/2) clk = ~clk;

    ialu_top u_ialu_top (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_code(op_code),
        .idx_s(idx_s), .idx_t(idx_t), .idx_d(idx_d), .imm_lo(imm_lo),
        .imm_hi(imm_hi), .imm5(imm5), .pc(pc), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data), .jmp_valid(jmp_valid), .jmp_target(jmp_target)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [4:0] c);
        case (c)
            5'd1, 5'd2, 5'd3, 5'd4: return "R2";
            5'd5:  return "R3";
            5'd6, 5'd7: return "R4";
            5'd9, 5'd11: return "R8";
            5'd10: return "R9";
            5'd12, 5'd13: return "R5";
            5'd14, 5'd15, 5'd16, 5'd17: return "R6";
            5'd8: return "R7";
            default: return "R13";
        endcase
    endfunction

    task automatic issue(input logic [4:0] c, input logic [3:0] s, input logic [3:0] t,
                         input logic [3:0] d, input logic [10:0] lo, input logic [3:0] hi,
                         input logic [4:0] i5, input logic [13:0] p, input string tag);
        logic [15:0] a, b, ev;
        logic [3:0]  ei;
        logic        ew, ctl, tk, fire_chk, fire_v;
        logic [13:0] br;
        logic [18:0] tg, fire_t;
        logic [14:0] p16;
        a = m[s]; b = m[t];
        ew = 0; ei = t; ev = '0; ctl = 0; tk = 0;
        br = p + 14'd8 + 14'({{3{lo[10]}}, lo, 3'b000});
        tg = {5'b0, br};
        p16 = {1'b0, p} + 15'd16;
        case (c)
            5'd1: begin ew = 1; ei = d; ev = a + b; end
            5'd2: begin ew = 1; ei = d; ev = a - b; end
            5'd3: begin ew = 1; ei = d; ev = a & b; end
            5'd4: begin ew = 1; ei = d; ev = a | b; end
            5'd5: begin ew = 1; ev = a + {{11{i5[4]}}, i5}; end
            5'd6: begin ew = 1; ev = a + {1'b0, hi, lo}; end
            5'd7: begin ew = 1; ev = a - {1'b0, hi, lo}; end
            5'd8: begin ctl = 1; tk = 1; end
            5'd9: begin ctl = 1; tk = 1; ew = 1; ev = 16'(p16 >> 3); end
            5'd10: begin ctl = 1; tk = 1; tg = {a, 3'b000}; end
            5'd11: begin ctl = 1; tk = 1; tg = {a, 3'b000}; ew = 1; ev = 16'(p16 >> 3); end
            5'd12: begin ctl = 1; tk = (a == b); end
            5'd13: begin ctl = 1; tk = (a != b); end
            5'd14: begin ctl = 1; tk = a[15]; end
            5'd15: begin ctl = 1; tk = $signed(a) > 0; end
            5'd16: begin ctl = 1; tk = $signed(a) <= 0; end
            5'd17: begin ctl = 1; tk = !a[15]; end
            default: begin end
        endcase
        if (ei == 0) ew = 0;
        fire_chk = 0; fire_v = 0; fire_t = NO_TGT;
        if (js == 1) begin
            fire_chk = 1; fire_v = p_taken; fire_t = p_tgt; js = 2;
        end else if (ctl) begin
            js = 1; p_taken = tk; p_tgt = tk ? tg : NO_TGT;
        end else js = 0;
        @(negedge clk);
        op_code = c; idx_s = s; idx_t = t; idx_d = d;
        imm_lo = lo; imm_hi = hi; imm5 = i5; pc = p; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(wb_en == ew, {tag, " wb_en"}, 32'(wb_en), 32'(ew));
        if (ew) begin
            chk(wb_idx == ei, {tag, " wb_idx"}, 32'(wb_idx), 32'(ei));
            chk(wb_data == ev, {tag, " wb_data"}, 32'(wb_data), 32'(ev));
            m[ei] = ev;
        end
        chk(jmp_valid == fire_v, "R10 jmp_valid", 32'(jmp_valid), 32'(fire_v));
        if (fire_chk) chk(jmp_target == fire_t, "R10 jmp_target", 32'(jmp_target), 32'(fire_t));
        if (js == 2) js = 0;
    endtask

    task automatic idle_check(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(jmp_valid == 1'b0, "R10 armed slot waits", 32'(jmp_valid), 0);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [4:0] c;
        seed = 32'd2024;
        void'($urandom(seed));
        for (int i = 0; i < 16; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wb_en == 0, "R12 reset wb_en", 32'(wb_en), 0);
        chk(jmp_valid == 0, "R12 reset jmp_valid", 32'(jmp_valid), 0);
        chk(jmp_target == NO_TGT, "R12 reset jmp_target", 32'(jmp_target), 32'(NO_TGT));
        issue(5'd1, 4'd3, 4'd7, 4'd5, 0, 0, 0, 0, "R12 regs zero");

        // R1: writes to register 0 are dropped, it still reads zero
        issue(5'd6, 4'd0, 4'd0, 0, 11'h123, 4'h1, 0, 0, "R1 write r0");
        issue(5'd4, 4'd0, 4'd0, 4'd2, 0, 0, 0, 0, "R1 read r0");
        // R4: largest 15-bit immediate
        issue(5'd6, 4'd0, 4'd1, 0, 11'h7FF, 4'hF, 0, 0, "R4 imm15 max");
        issue(5'd7, 4'd0, 4'd2, 0, 11'h001, 4'h8, 0, 0, "R4 sub imm15");
        // R3: most negative 5-bit immediate
        issue(5'd5, 4'd0, 4'd3, 0, 0, 0, 5'h10, 0, "R3 imm5 -16");
        issue(5'd5, 4'd0, 4'd4, 0, 0, 0, 5'h0F, 0, "R3 imm5 +15");
        // R6: 0x8000 is negative
        issue(5'd6, 4'd0, 4'd6, 0, 11'h000, 4'h0, 0, 0, "R4 zero");
        issue(5'd7, 4'd0, 4'd6, 0, 11'h000, 4'h0, 0, 0, "R4 zero sub");
        issue(5'd6, 4'd0, 4'd5, 0, 11'h000, 4'h8, 0, 0, "R4 set 0x4000");
        issue(5'd1, 4'd5, 4'd5, 4'd5, 0, 0, 0, 0, "R2 make 0x8000");
        issue(5'd15, 4'd5, 0, 0, 11'd4, 0, 0, 14'd64, "R6 gtz 0x8000");
        issue(5'd1, 4'd0, 4'd0, 4'd9, 0, 0, 0, 0, "R10 slot not taken");
        issue(5'd14, 4'd5, 0, 0, 11'd4, 0, 0, 14'd64, "R6 ltz 0x8000");
        issue(5'd1, 4'd0, 4'd0, 4'd9, 0, 0, 0, 0, "R10 slot taken");
        issue(5'd16, 4'd0, 0, 0, 11'd1, 0, 0, 14'd8, "R6 lez zero");
        issue(5'd1, 4'd0, 4'd0, 4'd9, 0, 0, 0, 0, "R10 slot lez");
        // R7: negative offset wraps below zero
        issue(5'd8, 0, 0, 0, 11'h7FE, 0, 0, 14'd0, "R7 wrap");
        idle_check(3);
        issue(5'd1, 4'd0, 4'd0, 4'd9, 0, 0, 0, 0, "R10 slot after wait");
        // R9: register jump with all ones
        issue(5'd7, 4'd0, 4'd8, 0, 11'h001, 4'h0, 0, 0, "R4 make 0xFFFF");
        issue(5'd11, 4'd8, 4'd10, 0, 0, 0, 0, 14'h3FF8, "R8 R9 link jump");
        // R11: branch in delay slot writes link, transfer dropped
        issue(5'd9, 0, 4'd11, 0, 11'd20, 0, 0, 14'd800, "R11 link in slot");
        issue(5'd1, 4'd0, 4'd0, 4'd9, 0, 0, 0, 0, "R11 no second fire");
        // R13: undefined code
        issue(5'd31, 4'd8, 4'd8, 4'd8, 0, 0, 0, 0, "R13 undefined");
        issue(5'd4, 4'd8, 4'd0, 4'd12, 0, 0, 0, 0, "R13 reg kept");

        for (int n = 0; n < 600; n++) begin
            c = ($urandom_range(0, 19) == 0) ? 5'd31 : 5'($urandom_range(1, 17));
            issue(c, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                  4'($urandom_range(0, 15)), 11'($urandom), 4'($urandom), 5'($urandom),
                  14'($urandom) & 14'h3FF8, req_of(c));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule